// File: doc/BRIEF.md
# Scale Mode and Factor Generator

This block works out the scaling set-up for one 2D image transfer. Given the active width and height of the source window and of the destination window, plus a two-bit rotation code, it decides per axis whether the image is shrunk, enlarged or passed at unit scale. For every scaled axis it also produces a 16.16 normalised inverse ratio, packed into a 32-bit factor word. Scaling is applied before rotation. For quarter-turn rotations, the destination width is therefore compared with the source height, and the destination height with the source width.

A single start pulse captures the inputs. One shared restoring divider first computes the horizontal ratio and then the vertical ratio. Every start takes the same number of cycles, whatever the sizes. When both words are ready, the modes, the factor words and a range-error flag are published together, along with a one-cycle done pulse. These outputs then hold until the next completion.

Top module: `scale_factor_gen`

## Requirements
- R1: Each axis has its own 2-bit mode: 0 means no scaling (source equals destination), 1 means downscale (source larger) and 2 means upscale (source smaller). Code 3 never appears. When an axis has mode 0, its whole factor word is zero.
- R2: For a downscaled axis, the factor word holds floor(dst*65536/src)+1 in bits [15:0], and bits [31:16] are zero.
- R3: For an upscaled axis, the factor word holds floor((src-1)*65536/(dst-1)) in bits [31:16], and bits [15:0] are zero.
- R4: For rotation codes 1 and 3, the horizontal axis compares source width with destination height, and the vertical axis compares source height with destination width. For codes 0 and 2, width is compared with width and height with height.
- R5: Every size must lie in 34..8192. If any of the four is outside that range, err_o is 1, both modes are 0 and both words are zero. Otherwise err_o is 0.
- R6: A start sampled while idle raises busy_o from the next cycle. done_o is a one-cycle pulse 63 clock cycles after the sampling edge. busy_o is low while done_o is high.
- R7: A start pulse that arrives while busy_o is high is ignored. The results of the run in progress are unaffected, and no extra done pulse follows.
- R8: Mode, factor and error outputs change only together with a done pulse, and hold their values at all other times, including during a run.
- R9: After reset, busy_o and done_o are 0, err_o is 0, both modes are 0 and both words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| src_w_i | input | 14 | Source active width |
| src_h_i | input | 14 | Source active height |
| dst_w_i | input | 14 | Destination active width |
| dst_h_i | input | 14 | Destination active height |
| rot_i | input | 2 | Rotation code: 0, 1 = 90, 2 = 180, 3 = 270 degrees |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | A size was out of range in the last run |
| hmode_o | output | 2 | Horizontal scale mode |
| vmode_o | output | 2 | Vertical scale mode |
| xfac_o | output | 32 | Horizontal factor word |
| yfac_o | output | 32 | Vertical factor word |

## Verification
The generator is driven with several kinds of size pairs. Equal pairs check that a unit-scale axis gives a zero word. Shrinking-only and enlarging-only pairs, and a mix of the two, check that each ratio lands in its correct half-word with its own rounding. The range extremes of 34 and 8192 test the largest and smallest quotients the divider can produce.

The same size set is run under all four rotation codes, so that an axis swap shows up as a changed mode. Out-of-range sizes are used to check the error behaviour. A second start issued in the middle of a run checks that the running job keeps its own operands and that the published outputs do not move.

// File: rtl/scale_factor_pkg.sv
package scale_factor_pkg;

    typedef enum logic [1:0] {
        SCL_NONE = 2'd0,
        SCL_DOWN = 2'd1,
        SCL_UP   = 2'd2
    } scl_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LDH  = 3'd1,
        ST_RUNH = 3'd2,
        ST_LDV  = 3'd3,
        ST_RUNV = 3'd4,
        ST_FIN  = 3'd5
    } sfg_state_e;

endpackage

// File: rtl/scl_axis_prep.sv
// Chooses the scale mode of one axis and the divider operands for its ratio.
module scl_axis_prep
    import scale_factor_pkg::*;
#(
    parameter int SZ_W   = 14,
    parameter int FRAC_W = 16,
    localparam int NUM_W = SZ_W + FRAC_W
) (
    input  logic [SZ_W-1:0]  src_i,
    input  logic [SZ_W-1:0]  dst_i,
    output scl_mode_e        mode_o,
    output logic [NUM_W-1:0] num_o,
    output logic [SZ_W-1:0]  den_o,
    output logic             bump_o
);
    logic [SZ_W-1:0] src_m1;
    logic [SZ_W-1:0] dst_m1;

    always_comb begin
        src_m1 = src_i - SZ_W'(1);
        dst_m1 = dst_i - SZ_W'(1);
        if (src_i == dst_i) begin
            mode_o = SCL_NONE;
            num_o  = '0;
            den_o  = SZ_W'(1);
            bump_o = 1'b0;
        end else if (src_i > dst_i) begin
            // shrink: smaller size over larger, then one is added
            mode_o = SCL_DOWN;
            num_o  = {dst_i, {FRAC_W{1'b0}}};
            den_o  = src_i;
            bump_o = 1'b1;
        end else begin
            // enlarge: ratio of the sizes each reduced by one
            mode_o = SCL_UP;
            num_o  = {src_m1, {FRAC_W{1'b0}}};
            den_o  = dst_m1;
            bump_o = 1'b0;
        end
    end
endmodule

// File: rtl/scl_restoring_div.sv
// Unsigned restoring divider, one quotient bit per cycle, NUM_W steps per load.
module scl_restoring_div #(
    parameter int NUM_W = 30,
    parameter int DEN_W = 14,
    parameter int QUO_W = 16,
    localparam int CNT_W = $clog2(NUM_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             last_o,
    output logic [QUO_W-1:0] quo_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [NUM_W-1:0] acc;
        logic [DEN_W-1:0] rem;
        logic [DEN_W-1:0] den;
    } div_regs_t;

    div_regs_t r_d, r_q;
    logic [DEN_W:0] trial;
    logic [DEN_W:0] diff;
    logic           fits;

    always_comb begin
        r_d   = r_q;
        trial = {r_q.rem, r_q.acc[NUM_W-1]};
        diff  = trial - {1'b0, r_q.den};
        fits  = (trial >= {1'b0, r_q.den});
        if (load_i) begin
            r_d.cnt = CNT_W'(NUM_W);
            r_d.acc = num_i;
            r_d.rem = '0;
            r_d.den = den_i;
        end else if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - CNT_W'(1);
            r_d.acc = {r_q.acc[NUM_W-2:0], fits};
            r_d.rem = fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign last_o = (r_q.cnt == CNT_W'(1));
    assign quo_o  = r_q.acc[QUO_W-1:0];
endmodule

// File: rtl/scale_factor_gen.sv
module scale_factor_gen
    import scale_factor_pkg::*;
#(
    parameter int SZ_W   = 14,
    parameter int MIN_SZ = 34,
    parameter int MAX_SZ = 8192,
    parameter int FRAC_W = 16,
    localparam int NUM_W  = SZ_W + FRAC_W,
    localparam int WORD_W = 2 * FRAC_W,
    localparam int AXES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SZ_W-1:0]   src_w_i,
    input  logic [SZ_W-1:0]   src_h_i,
    input  logic [SZ_W-1:0]   dst_w_i,
    input  logic [SZ_W-1:0]   dst_h_i,
    input  logic [1:0]        rot_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [1:0]        hmode_o,
    output logic [1:0]        vmode_o,
    output logic [WORD_W-1:0] xfac_o,
    output logic [WORD_W-1:0] yfac_o
);
    typedef struct packed {
        sfg_state_e        st;
        logic [SZ_W-1:0]   hs;
        logic [SZ_W-1:0]   hd;
        logic [SZ_W-1:0]   vs;
        logic [SZ_W-1:0]   vd;
        logic              bad;
        logic [WORD_W-1:0] xtmp;
        logic [WORD_W-1:0] xo;
        logic [WORD_W-1:0] yo;
        scl_mode_e         hm;
        scl_mode_e         vm;
        logic              err;
        logic              done;
    } top_regs_t;

    top_regs_t r_d, r_q;

    logic [SZ_W-1:0]  ax_src  [AXES];
    logic [SZ_W-1:0]  ax_dst  [AXES];
    scl_mode_e        ax_mode [AXES];
    scl_mode_e        eff_mode[AXES];
    logic [NUM_W-1:0] ax_num  [AXES];
    logic [SZ_W-1:0]  ax_den  [AXES];
    logic             ax_bump [AXES];

    logic             div_load;
    logic             div_sel;
    logic             div_last;
    logic [FRAC_W-1:0] div_quo;
    logic             quarter_turn;
    logic             any_bad;

    function automatic logic in_range(logic [SZ_W-1:0] v);
        return (v >= SZ_W'(MIN_SZ)) && (v <= SZ_W'(MAX_SZ));
    endfunction

    function automatic logic [WORD_W-1:0] fac_word(scl_mode_e m, logic [FRAC_W-1:0] q,
                                                   logic b);
        case (m)
            SCL_DOWN: return {{FRAC_W{1'b0}}, q + FRAC_W'(b)};
            SCL_UP:   return {q, {FRAC_W{1'b0}}};
            default:  return '0;
        endcase
    endfunction

    assign ax_src[0] = r_q.hs;
    assign ax_dst[0] = r_q.hd;
    assign ax_src[1] = r_q.vs;
    assign ax_dst[1] = r_q.vd;

    for (genvar a = 0; a < AXES; a++) begin : g_axis
        scl_axis_prep #(
            .SZ_W  (SZ_W),
            .FRAC_W(FRAC_W)
        ) u_prep (
            .src_i (ax_src[a]),
            .dst_i (ax_dst[a]),
            .mode_o(ax_mode[a]),
            .num_o (ax_num[a]),
            .den_o (ax_den[a]),
            .bump_o(ax_bump[a])
        );
        assign eff_mode[a] = r_q.bad ? SCL_NONE : ax_mode[a];
    end

    assign div_load = (r_q.st == ST_LDH) || (r_q.st == ST_LDV);
    assign div_sel  = (r_q.st == ST_LDV);

    scl_restoring_div #(
        .NUM_W(NUM_W),
        .DEN_W(SZ_W),
        .QUO_W(FRAC_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(div_load),
        .num_i (ax_num[div_sel]),
        .den_i (ax_den[div_sel]),
        .last_o(div_last),
        .quo_o (div_quo)
    );

    assign quarter_turn = (rot_i == 2'd1) || (rot_i == 2'd3);
    assign any_bad = !(in_range(src_w_i) && in_range(src_h_i) &&
                       in_range(dst_w_i) && in_range(dst_h_i));

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    // scaling precedes rotation: a quarter turn crosses the axes
                    r_d.hs  = src_w_i;
                    r_d.hd  = quarter_turn ? dst_h_i : dst_w_i;
                    r_d.vs  = src_h_i;
                    r_d.vd  = quarter_turn ? dst_w_i : dst_h_i;
                    r_d.bad = any_bad;
                    r_d.st  = ST_LDH;
                end
            end
            ST_LDH:  r_d.st = ST_RUNH;
            ST_RUNH: if (div_last) r_d.st = ST_LDV;
            ST_LDV: begin
                r_d.xtmp = fac_word(eff_mode[0], div_quo, ax_bump[0]);
                r_d.st   = ST_RUNV;
            end
            ST_RUNV: if (div_last) r_d.st = ST_FIN;
            ST_FIN: begin
                r_d.xo   = r_q.xtmp;
                r_d.yo   = fac_word(eff_mode[1], div_quo, ax_bump[1]);
                r_d.hm   = eff_mode[0];
                r_d.vm   = eff_mode[1];
                r_d.err  = r_q.bad;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy_o  = (r_q.st != ST_IDLE);
    assign done_o  = r_q.done;
    assign err_o   = r_q.err;
    assign hmode_o = r_q.hm;
    assign vmode_o = r_q.vm;
    assign xfac_o  = r_q.xo;
    assign yfac_o  = r_q.yo;
endmodule

// File: rtl/scale_factor_gen_chk.sv
module scale_factor_gen_chk #(
    parameter int FRAC_W = 16,
    localparam int WORD_W = 2 * FRAC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic [1:0]        hmode_o,
    input logic [1:0]        vmode_o,
    input logic [WORD_W-1:0] xfac_o,
    input logic [WORD_W-1:0] yfac_o
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R6
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R6
    AST_MODE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (hmode_o != 2'd3) && (vmode_o != 2'd3)); // R1
    AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((hmode_o == 2'd0) |-> (xfac_o == '0)) and
        ((vmode_o == 2'd0) |-> (yfac_o == '0))); // R1
    AST_DOWN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((hmode_o == 2'd1) |-> (xfac_o[WORD_W-1:FRAC_W] == '0)) and
        ((vmode_o == 2'd1) |-> (yfac_o[WORD_W-1:FRAC_W] == '0))); // R2
    AST_UP_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((hmode_o == 2'd2) |-> (xfac_o[FRAC_W-1:0] == '0)) and
        ((vmode_o == 2'd2) |-> (yfac_o[FRAC_W-1:0] == '0))); // R3
    AST_ERR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (hmode_o == 2'd0 && vmode_o == 2'd0 &&
                   xfac_o == '0 && yfac_o == '0)); // R5
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(xfac_o) && $stable(yfac_o) && $stable(hmode_o) &&
          $stable(vmode_o) && $stable(err_o)) |-> done_o); // R8
endmodule

bind scale_factor_gen scale_factor_gen_chk #(.FRAC_W(FRAC_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .busy_o (busy_o),
    .done_o (done_o),
    .err_o  (err_o),
    .hmode_o(hmode_o),
    .vmode_o(vmode_o),
    .xfac_o (xfac_o),
    .yfac_o (yfac_o)
);

// File: tb/scale_factor_gen_tb.sv
`timescale 1ns/1ps
module scale_factor_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [13:0] src_w_i = '0, src_h_i = '0, dst_w_i = '0, dst_h_i = '0;
    logic [1:0]  rot_i = '0;
    logic        busy_o, done_o, err_o;
    logic [1:0]  hmode_o, vmode_o;
    logic [31:0] xfac_o, yfac_o;

    int n_chk = 0;
    int n_fail = 0;
    int wd = 0;

    always #10 clk = ~clk;

    scale_factor_gen u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .src_w_i(src_w_i), .src_h_i(src_h_i), .dst_w_i(dst_w_i), .dst_h_i(dst_h_i),
        .rot_i(rot_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .hmode_o(hmode_o), .vmode_o(vmode_o), .xfac_o(xfac_o), .yfac_o(yfac_o)
    );

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung (act %0d cycles, exp < 100000)", wd);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(string req, string what, longint act, longint exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: act %0d exp %0d", req, what, act, exp);
        end
    endtask

    function automatic void ref_axis(int s, int d, output int m, output longint w);
        if (s == d) begin m = 0; w = 0; end
        else if (s > d) begin m = 1; w = ((longint'(d) * 65536) / s) + 1; end
        else begin m = 2; w = ((longint'(s - 1) * 65536) / (d - 1)) << 16; end
    endfunction

    function automatic bit ok_sz(int v);
        return (v >= 34) && (v <= 8192);
    endfunction

    // start a job, optionally poke a second start mid-run, and check everything
    task automatic run(string req, int sw, int sh, int dw, int dh, int rot, bit inject);
        int hm, vm, cyc;
        longint xw, yw;
        bit bad, odd;
        logic [31:0] px, py;
        odd = (rot == 1) || (rot == 3);
        bad = !(ok_sz(sw) && ok_sz(sh) && ok_sz(dw) && ok_sz(dh));
        ref_axis(sw, odd ? dh : dw, hm, xw);
        ref_axis(sh, odd ? dw : dh, vm, yw);
        if (bad) begin hm = 0; vm = 0; xw = 0; yw = 0; end
        px = xfac_o; py = yfac_o;
        @(negedge clk);
        src_w_i = 14'(sw); src_h_i = 14'(sh); dst_w_i = 14'(dw); dst_h_i = 14'(dh);
        rot_i = 2'(rot); start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check("R6", "busy after start", busy_o, 1);
        cyc = 0;
        while (!done_o && cyc < 200) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
            if (inject && cyc == 10) begin
                src_w_i = 14'd500; src_h_i = 14'd700; dst_w_i = 14'd900; dst_h_i = 14'd100;
                rot_i = 2'd1; start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            if (inject && cyc == 20) begin
                check("R8", "xfac held mid-run", xfac_o, px);
                check("R8", "yfac held mid-run", yfac_o, py);
            end
        end
        check("R6", "done latency", cyc, 63);
        check("R6", "busy low at done", busy_o, 0);
        check(req, "hmode", hmode_o, hm);
        check(req, "vmode", vmode_o, vm);
        check(req, "xfac", xfac_o, xw);
        check(req, "yfac", yfac_o, yw);
        check("R5", "err flag", err_o, bad);
        @(negedge clk);
        check("R6", "done is one pulse", done_o, 0);
        if (inject) begin
            for (int k = 0; k < 80; k++) begin
                @(negedge clk);
                if (done_o) check("R7", "stray done after ignored start", 1, 0);
            end
            check("R7", "no restart from ignored start", busy_o, 0);
        end
    endtask

    task automatic t_reset();
        check("R9", "busy", busy_o, 0);
        check("R9", "done", done_o, 0);
        check("R9", "err", err_o, 0);
        check("R9", "hmode", hmode_o, 0);
        check("R9", "vmode", vmode_o, 0);
        check("R9", "xfac", xfac_o, 0);
        check("R9", "yfac", yfac_o, 0);
    endtask

    task automatic t_hold();
        logic [31:0] x0, y0;
        logic [1:0] h0, v0;
        x0 = xfac_o; y0 = yfac_o; h0 = hmode_o; v0 = vmode_o;
        repeat (25) @(negedge clk);
        check("R8", "xfac hold", xfac_o, x0);
        check("R8", "yfac hold", yfac_o, y0);
        check("R8", "hmode hold", hmode_o, h0);
        check("R8", "vmode hold", vmode_o, v0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run("R1", 100, 100, 100, 100, 0, 0);          // unit scale both axes
        run("R2", 640, 480, 320, 240, 0, 0);          // shrink both
        run("R3", 160, 120, 1280, 720, 0, 0);         // enlarge both
        run("R2_R3", 800, 200, 400, 600, 0, 0);       // mixed
        t_hold();
        run("R4", 640, 480, 480, 640, 1, 0);          // quarter turn: both unit
        run("R4", 640, 480, 480, 640, 0, 0);          // no turn: both scaled
        run("R4", 300, 200, 100, 900, 3, 0);          // 270: up / down
        run("R4", 300, 200, 100, 900, 2, 0);          // 180: down / up
        run("R2_R3", 8192, 34, 34, 8192, 0, 0);       // extremes
        run("R1", 34, 8192, 34, 8192, 2, 0);
        run("R5", 33, 100, 100, 100, 0, 0);           // below range
        run("R5", 100, 100, 100, 8193, 1, 0);         // above range
        run("R5", 200, 200, 100, 400, 0, 0);          // clean run clears flag
        run("R7", 1000, 300, 250, 600, 0, 1);         // start while busy
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule